// File: doc/BRIEF.md
# Addressable Tap Delay Line

This block is a serial delay line whose output point is chosen while it runs. Each lane is a chain of sixteen storage stages. On every clock edge with the enable high, a new bit enters the first stage and every stored bit moves one stage further. A tap address selects which stage drives the data output. The read is combinational, so changing the address changes the output at once, with no flush or refill. This lets a designer balance pipeline paths of unequal length at run time.

The last stage of every lane also drives a cascade output. Feeding it into the serial input of a second unit gives delays longer than sixteen edges. A build-time switch inserts one output flip-flop after the tap selector, which adds one more enabled edge of delay. Several lanes share the clock, enable and tap address. Each lane shifts its own input bit. There is no reset port: the stages take a parameter pattern at power-up.

Top module: `tapdl_line`

## Requirements
- R1: On a rising clock edge with `shift_en` high, every lane loads its `ser_in` bit into stage 0, and stage i takes the old value of stage i-1 for i = 1 to 15.
- R2: With `OUT_REG` = 0 and tap address N (0 to 15), `tap_out` equals the bit that entered N+1 enabled edges earlier. Tap 0 gives the most recent bit, and tap 15 gives a delay of 16.
- R3: A change of `tap_sel` between edges shows at `tap_out` in the same cycle, without any shift. The output becomes the stage named by the new address.
- R4: `chain_out` always shows stage 15 of each lane. A second unit fed from it, with tap N, gives a total delay of N+17 enabled edges (N+18 when that unit has `OUT_REG` = 1).
- R5: With `OUT_REG` = 1, `tap_out` is a register. On each enabled edge it loads the stage chosen by `tap_sel` before that edge, which adds one edge of delay. The register powers up to 0.
- R6: With `shift_en` low, a clock edge leaves all stages, `chain_out` and the output register unchanged.
- R7: At power-up, stage i of every lane holds bit i of parameter `INIT`. Before any enabled edge, `tap_out` reads `INIT[tap_sel]` on every lane, and `chain_out` reads `INIT[15]`.
- R8: Lanes are independent. Bit k of `tap_out` and of `chain_out` depends only on bit k of `ser_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| shift_en | input | 1 | Shift enable; high moves data one stage |
| ser_in | input | WIDTH | Serial input, one bit per lane |
| tap_sel | input | 4 | Tap address, stage number 0..15 |
| tap_out | output | WIDTH | Selected stage, optionally registered |
| chain_out | output | WIDTH | Last stage of each lane, for chaining |

## Verification
On every cycle, the embedded properties check that enabled edges move each stage into the next and load stage 0 from the input. They also check that disabled edges freeze the stages and the output register, and that the output register captures its input. Only the bench scenarios can show end-to-end delays: tap N giving N+1, chained units giving N+17 or N+18, and the same-cycle response to a tap change. The bench checks these against a history model, both through vectors and through sequences with random enable, data and addresses. The power-up pattern is visible only in the bench's first reads.

// File: rtl/tapdl_pkg.sv
package tapdl_pkg;
    // Fixed stage count of one unit; the tap address width follows from it.
    localparam int unsigned STAGES = 16;
    localparam int unsigned SEL_W  = $clog2(STAGES);

    typedef logic [SEL_W-1:0] tap_t;
endpackage

// File: rtl/tapdl_stages.sv
// One lane: a chain of DEPTH stages, preloaded from INIT, shifted on enable.
module tapdl_stages #(
    parameter int unsigned   DEPTH = 16,
    parameter logic [DEPTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] stages,
    output logic             last_bit
);
    logic [DEPTH-1:0] stg_q = INIT;
    logic             warm  = 1'b0;

    always_ff @(posedge clk) begin
        warm <= 1'b1;
        if (shift_en) begin
            stg_q <= {stg_q[DEPTH-2:0], bit_in};
        end
    end

    assign stages   = stg_q;
    assign last_bit = stg_q[DEPTH-1];

    // R1: entry stage takes the input bit on an enabled edge
    a_r1_entry_load: assert property (@(posedge clk) disable iff (!warm)
        (warm && shift_en) |=> (stg_q[0] == $past(bit_in)));

    // R1: every later stage takes its neighbour's old value
    a_r1_stage_move: assert property (@(posedge clk) disable iff (!warm)
        (warm && shift_en) |=> (stg_q[DEPTH-1:1] == $past(stg_q[DEPTH-2:0])));

    // R6: nothing moves without enable
    a_r6_stage_hold: assert property (@(posedge clk) disable iff (!warm)
        (warm && !shift_en) |=> $stable(stg_q));

    // R4: the cascade bit follows the stage before it one enabled edge later
    a_r4_chain_follow: assert property (@(posedge clk) disable iff (!warm)
        (warm && shift_en) |=> (last_bit == $past(stg_q[DEPTH-2])));
endmodule

// File: rtl/tapdl_select.sv
// Combinational read of one stage chosen by the address.
module tapdl_select #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic [DEPTH-1:0] stages,
    input  logic [SEL_W-1:0] sel,
    output logic             picked
);
    always_comb begin
        picked = stages[sel];
    end
endmodule

// File: rtl/tapdl_outstage.sv
// Optional output flip-flop: pass-through when ENABLE is 0.
module tapdl_outstage #(
    parameter bit ENABLE = 1'b0
) (
    input  logic clk,
    input  logic shift_en,
    input  logic d,
    output logic q
);
    generate
        if (ENABLE) begin : g_reg
            logic q_r  = 1'b0;
            logic warm = 1'b0;

            always_ff @(posedge clk) begin
                warm <= 1'b1;
                if (shift_en) begin
                    q_r <= d;
                end
            end

            assign q = q_r;

            // R5: register captures the selected stage on an enabled edge
            a_r5_out_capture: assert property (@(posedge clk) disable iff (!warm)
                (warm && shift_en) |=> (q_r == $past(d)));

            // R6: register holds without enable
            a_r6_out_hold: assert property (@(posedge clk) disable iff (!warm)
                (warm && !shift_en) |=> $stable(q_r));
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/tapdl_line.sv
// Multi-lane addressable tap delay line with cascade outputs.
module tapdl_line
    import tapdl_pkg::*;
#(
    parameter int unsigned       WIDTH   = 2,
    parameter bit                OUT_REG = 1'b0,
    parameter logic [STAGES-1:0] INIT    = 16'h3C96
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] ser_in,
    input  logic [SEL_W-1:0] tap_sel,
    output logic [WIDTH-1:0] tap_out,
    output logic [WIDTH-1:0] chain_out
);
    generate
        for (genvar k = 0; k < WIDTH; k++) begin : g_lane
            logic [STAGES-1:0] lane_stg;
            logic              lane_pick;

            tapdl_stages #(
                .DEPTH (STAGES),
                .INIT  (INIT)
            ) u_stages (
                .clk      (clk),
                .shift_en (shift_en),
                .bit_in   (ser_in[k]),
                .stages   (lane_stg),
                .last_bit (chain_out[k])
            );

            tapdl_select #(
                .DEPTH (STAGES),
                .SEL_W (SEL_W)
            ) u_select (
                .stages (lane_stg),
                .sel    (tap_sel),
                .picked (lane_pick)
            );

            tapdl_outstage #(
                .ENABLE (OUT_REG)
            ) u_out (
                .clk      (clk),
                .shift_en (shift_en),
                .d        (lane_pick),
                .q        (tap_out[k])
            );
        end
    endgenerate
endmodule

// File: tb/tapdl_line_test.sv
module tapdl_line_test;
    localparam int unsigned W = 2;
    localparam logic [15:0] INITV = 16'h3C96;
    localparam int unsigned NVEC = 20;
    // Vector: [10] enable, [9:8] data, [7:4] tap of first unit, [3:0] tap of chained unit
    localparam logic [10:0] VEC [0:NVEC-1] = '{
        11'h5_00, 11'h6_10, 11'h7_2F, 11'h4_33, 11'h5_F0,
        11'h2_00, 11'h3_F5, 11'h6_08, 11'h5_1E, 11'h7_71,
        11'h4_A2, 11'h1_A2, 11'h6_C9, 11'h5_E4, 11'h7_FF,
        11'h6_0C, 11'h0_0C, 11'h5_57, 11'h4_6A, 11'h7_B3
    };

    logic         clk = 1'b0;
    logic         shift_en = 1'b0;
    logic [W-1:0] ser_in = '0;
    logic [3:0]   tap_a = 4'd0;
    logic [3:0]   tap_c = 4'd0;
    logic [W-1:0] out_a, casc_a, out_c, casc_c;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cycles   = 0;

    logic [W-1:0] hist [0:47];
    logic [W-1:0] oreg_model = '0;

    always #2.5 clk = ~clk;

    tapdl_line #(.WIDTH(W), .OUT_REG(1'b0), .INIT(INITV)) uut (
        .clk(clk), .shift_en(shift_en), .ser_in(ser_in), .tap_sel(tap_a),
        .tap_out(out_a), .chain_out(casc_a)
    );

    tapdl_line #(.WIDTH(W), .OUT_REG(1'b1), .INIT(INITV)) uut_chain (
        .clk(clk), .shift_en(shift_en), .ser_in(casc_a), .tap_sel(tap_c),
        .tap_out(out_c), .chain_out(casc_c)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive at negedge, let the edge happen, update the model, check away from the edge.
    task automatic step(input logic en, input logic [W-1:0] d, input logic [3:0] ta, input logic [3:0] tc);
        logic [W-1:0] old_a, old_ca, old_cc, old_oc;
        @(negedge clk);
        shift_en = en; ser_in = d; tap_a = ta; tap_c = tc;
        #1;
        old_a = out_a; old_ca = casc_a; old_cc = casc_c; old_oc = out_c;
        @(posedge clk);
        #1;
        if (en) begin
            oreg_model = hist[16 + int'(tc)];
            for (int i = 47; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
            check("R1 R8 newest bit at tap 0", hist[0], d);
            check("R2 R8 tap delay", out_a, hist[int'(ta)]);
            check("R4 cascade of first unit", casc_a, hist[15]);
            check("R4 R5 chained registered tap", out_c, oreg_model);
            check("R4 cascade of second unit", casc_c, hist[31]);
        end else begin
            check("R6 hold tap output", out_a, old_a);
            check("R6 hold cascade", casc_a, old_ca);
            check("R6 hold second cascade", casc_c, old_cc);
            check("R6 hold output register", out_c, old_oc);
            check("R6 model agrees", out_a, hist[int'(ta)]);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 48; i++) hist[i] = {W{INITV[i % 16]}};

        // R7: power-up contents, before any edge
        #1;
        for (int t = 0; t < 16; t++) begin
            tap_a = 4'(t);
            #1;
            check("R7 power-up tap read", out_a, {W{INITV[t]}});
        end
        check("R7 power-up cascade", casc_a, {W{INITV[15]}});
        check("R5 R7 output register powers up 0", out_c, '0);

        // Vector table walk
        for (int v = 0; v < int'(NVEC); v++) begin
            step(VEC[v][10], VEC[v][9:8], VEC[v][7:4], VEC[v][3:0]);
        end

        // Random enable, data and taps, with same-cycle tap changes
        for (int n = 0; n < 400; n++) begin
            logic [3:0] nt;
            step(($urandom % 4) != 0, W'($urandom), 4'($urandom), 4'($urandom));
            nt = 4'($urandom);
            tap_a = nt;
            #1;
            check("R3 tap change without shift", out_a, hist[int'(nt)]);
        end

        // Corner: full 16-deep delay at tap 15, then a hold with ce low
        for (int n = 0; n < 20; n++) step(1'b1, W'(n), 4'd15, 4'd15);
        check("R2 tap 15 equals cascade", out_a, casc_a);
        step(1'b0, 2'b11, 4'd15, 4'd0);
        check("R6 tap 15 held", out_a, hist[15]);

        finish_run();
    end
endmodule